// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date in seven byte-wide packed BCD registers: seconds, minutes, hours, day of week, date, month and year. A one-cycle pulse on `tick_1hz` arrives once per second from an external prescaler. The block latches the pulse as a pending tick. A small state machine then advances seconds and ripples any carry upward, one register per clock cycle.

Hours run in either a 24-hour format or a 12-hour format with a PM flag. Month lengths follow the calendar. February gains a 29th day whenever the two-digit year is a multiple of four. A halt bit in the seconds register freezes the count. A host writes any register through a parallel write port, and reads any register through a combinational read port.

The state machine has six states. ST_IDLE waits for a pending tick. While the halt bit is clear it bumps seconds, moves to ST_MIN when seconds wrap, and otherwise stays. ST_MIN bumps minutes and moves to ST_HOUR on a wrap, otherwise back to ST_IDLE. ST_HOUR bumps hours and moves to ST_DATE on a day rollover, otherwise back to ST_IDLE. ST_DATE bumps both date and day of week and moves to ST_MONTH on a month-end wrap, otherwise back to ST_IDLE. ST_MONTH bumps the month and moves to ST_YEAR on a wrap, otherwise back to ST_IDLE. ST_YEAR bumps the year and always returns to ST_IDLE. A host write holds the machine in its current state for that cycle. A write to the seconds register sends the machine straight to ST_IDLE.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read: seconds 0x00, minutes 0x00, hours 0x00 (24-hour), date 0x01, month 0x01, day of week 0x01, year 0x00.
- R2: Each tick that is not halted advances seconds by one in BCD (for example 0x09 to 0x10). Seconds wrap from 0x59 to 0x00 and carry into minutes.
- R3: Minutes count 0x00 to 0x59. The wrap from 0x59 to 0x00 carries into hours.
- R4: With hours bit 7 at 0 (24-hour mode), hours count 0x00 to 0x23. Bit 5 serves as the second tens bit, as in 0x19 to 0x20. The wrap from 0x23 to 0x00 carries into the date.
- R5: With hours bit 7 at 1 (12-hour mode), bits 4:0 count 12, 01 … 11 in BCD and bit 5 is the PM flag (1 = PM). The flag toggles on the step from 11 to 12. Only 11 PM to 12 AM carries into the date.
- R6: Date counts from 0x01 up to the last day of the month: 30 for months 04, 06, 09 and 11, and 31 for the others except February. After the last day it returns to 0x01 and carries into the month.
- R7: February ends on day 0x29 when the year value, read as a decimal number, is divisible by four (including 00). Otherwise it ends on day 0x28.
- R8: Day of week steps once per date advance, counting 1 to 7 and then back to 1.
- R9: Month counts 0x01 to 0x12, and the wrap carries into the year. Year counts 0x00 to 0x99 and then wraps to 0x00.
- R10: While seconds bit 7 is 1, ticks are dropped and nothing counts. After software writes bit 7 to 0, counting resumes with the next tick.
- R11: A host write lands in its cycle and defers that cycle's increment step without losing it. A write to seconds also discards any tick not yet applied.
- R12: Select codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year. Code 7 reads 0x00, and writing it has no effect. Bits with no storage read 0: minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5, day-of-week bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Byte to load |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 8 | Selected register value (combinational) |

## Verification
The bench aims at the calendar boundaries where a naive counter goes wrong.

- A binary rather than BCD leap test would call year 0x10 a leap year, and the bench would see day 29 appear.
- A counter that ignores month length would show April 31.
- A 12-hour counter that toggles PM on 12-to-1, or that carries on 11 AM, would show the wrong flag or an early date change.
- A write coinciding with a tick, or landing mid-carry, is checked by its result. Losing the carry leaves minutes unchanged. Failing to clear the pending tick shows one extra second.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MIN   = 3'd1,
        ST_HOUR  = 3'd2,
        ST_DATE  = 3'd3,
        ST_MONTH = 3'd4,
        ST_YEAR  = 3'd5
    } rtc_state_e;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_SEC   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_MIN   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_HOUR  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DATE  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_MONTH = 3'd4;
    localparam logic [SEL_W-1:0] SEL_DOW   = 3'd5;
    localparam logic [SEL_W-1:0] SEL_YEAR  = 3'd6;

    // two-digit BCD increment without range check
    function automatic logic [7:0] bcd_inc2(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    localparam int ND = W / 4;

    logic carry;

    always_comb begin
        nxt   = cur;
        carry = 1'b1;
        for (int d = 0; d < ND; d++) begin
            if (carry) begin
                if (cur[d*4 +: 4] >= 4'd9) begin
                    nxt[d*4 +: 4] = 4'd0;
                end else begin
                    nxt[d*4 +: 4] = cur[d*4 +: 4] + 4'd1;
                    carry = 1'b0;
                end
            end
        end
        // any value at or past the limit restarts at the low bound
        wrap = (cur >= hi);
        if (wrap)
            nxt = lo;
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_day
);
    logic [6:0] year_bin;
    logic       leap;

    always_comb begin
        year_bin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
        leap     = (year_bin[1:0] == 2'b00);
        if (month == 8'h02)
            last_day = leap ? 8'h29 : 8'h28;
        else if (month == 8'h04 || month == 8'h06 || month == 8'h09 || month == 8'h11)
            last_day = 8'h30;
        else
            last_day = 8'h31;
    end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
    import rtc_cal_pkg::*;
(
    input  logic [7:0] hour,
    output logic [7:0] nxt,
    output logic       day_carry
);
    logic [7:0] inc12;
    logic [7:0] inc24;

    always_comb begin
        inc12     = bcd_inc2({3'b000, hour[4:0]});
        inc24     = bcd_inc2({1'b0, hour[6:0]});
        nxt       = hour;
        day_carry = 1'b0;
        if (hour[7]) begin
            if (hour[4:0] >= 5'h12) begin
                nxt = {hour[7], 1'b0, hour[5], 5'h01};
            end else if (hour[4:0] == 5'h11) begin
                nxt       = {hour[7], 1'b0, ~hour[5], 5'h12};
                day_carry = hour[5];
            end else begin
                nxt = {hour[7], 1'b0, hour[5], inc12[4:0]};
            end
        end else begin
            if (hour[6:0] >= 7'h23) begin
                nxt       = 8'h00;
                day_carry = 1'b1;
            end else begin
                nxt = {1'b0, inc24[6:0]};
            end
        end
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int RW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1hz,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [RW-1:0]    wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [RW-1:0]    rd_data
);
    localparam logic [RW-1:0] MASK_MIN   = RW'(8'h7F);
    localparam logic [RW-1:0] MASK_HOUR  = RW'(8'hBF);
    localparam logic [RW-1:0] MASK_DATE  = RW'(8'h3F);
    localparam logic [RW-1:0] MASK_MONTH = RW'(8'h1F);
    localparam logic [RW-1:0] MASK_DOW   = RW'(8'h07);

    rtc_state_e st_q, st_d;
    logic [RW-1:0] sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q;
    logic          pend_q, pend_d;

    logic [RW-1:0] sec_nxt, min_nxt, hour_nxt, date_nxt, month_nxt, dow_nxt, year_nxt;
    logic          sec_wrap, min_wrap, hour_carry, date_wrap, month_wrap, dow_wrap, year_wrap;
    logic [RW-1:0] last_day;
    logic          sec_write;
    logic          consume;

    rtc_bcd_wrap #(.W(RW)) u_sec   (.cur({1'b0, sec_q[6:0]}), .lo(8'h00), .hi(8'h59),
                                    .nxt(sec_nxt), .wrap(sec_wrap));
    rtc_bcd_wrap #(.W(RW)) u_min   (.cur(min_q), .lo(8'h00), .hi(8'h59),
                                    .nxt(min_nxt), .wrap(min_wrap));
    rtc_bcd_wrap #(.W(RW)) u_date  (.cur(date_q), .lo(8'h01), .hi(last_day),
                                    .nxt(date_nxt), .wrap(date_wrap));
    rtc_bcd_wrap #(.W(RW)) u_dow   (.cur(dow_q), .lo(8'h01), .hi(8'h07),
                                    .nxt(dow_nxt), .wrap(dow_wrap));
    rtc_bcd_wrap #(.W(RW)) u_month (.cur(month_q), .lo(8'h01), .hi(8'h12),
                                    .nxt(month_nxt), .wrap(month_wrap));
    rtc_bcd_wrap #(.W(RW)) u_year  (.cur(year_q), .lo(8'h00), .hi(8'h99),
                                    .nxt(year_nxt), .wrap(year_wrap));

    rtc_month_len u_mlen (.month(month_q), .year(year_q), .last_day(last_day));

    rtc_hour_step u_hour (.hour(hour_q), .nxt(hour_nxt), .day_carry(hour_carry));

    assign sec_write = wr_en && (wr_sel == SEL_SEC);
    assign consume   = (st_q == ST_IDLE) && !wr_en;

    // next state and pending tick
    always_comb begin
        st_d   = st_q;
        pend_d = (tick_1hz || (pend_q && !consume)) && !sec_write;
        if (!wr_en) begin
            unique case (st_q)
                ST_IDLE:  if (pend_q && !sec_q[7] && sec_wrap) st_d = ST_MIN;
                ST_MIN:   st_d = min_wrap   ? ST_HOUR  : ST_IDLE;
                ST_HOUR:  st_d = hour_carry ? ST_DATE  : ST_IDLE;
                ST_DATE:  st_d = date_wrap  ? ST_MONTH : ST_IDLE;
                ST_MONTH: st_d = month_wrap ? ST_YEAR  : ST_IDLE;
                ST_YEAR:  st_d = ST_IDLE;
            endcase
        end else if (sec_write) begin
            st_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    // register file updates driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q   <= '0;
            min_q   <= '0;
            hour_q  <= '0;
            date_q  <= RW'(8'h01);
            month_q <= RW'(8'h01);
            dow_q   <= RW'(8'h01);
            year_q  <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_SEC:   sec_q   <= wr_data;
                SEL_MIN:   min_q   <= wr_data & MASK_MIN;
                SEL_HOUR:  hour_q  <= wr_data & MASK_HOUR;
                SEL_DATE:  date_q  <= wr_data & MASK_DATE;
                SEL_MONTH: month_q <= wr_data & MASK_MONTH;
                SEL_DOW:   dow_q   <= wr_data & MASK_DOW;
                SEL_YEAR:  year_q  <= wr_data;
                default:   ;
            endcase
        end else begin
            unique case (st_q)
                ST_IDLE:  if (pend_q && !sec_q[7]) sec_q <= sec_nxt;
                ST_MIN:   min_q <= min_nxt;
                ST_HOUR:  hour_q <= hour_nxt;
                ST_DATE: begin
                    date_q <= date_nxt;
                    dow_q  <= dow_nxt;
                end
                ST_MONTH: month_q <= month_nxt;
                ST_YEAR:  year_q <= year_nxt;
            endcase
        end
    end

    // read port
    always_comb begin
        case (rd_sel)
            SEL_SEC:   rd_data = sec_q;
            SEL_MIN:   rd_data = min_q;
            SEL_HOUR:  rd_data = hour_q;
            SEL_DATE:  rd_data = date_q;
            SEL_MONTH: rd_data = month_q;
            SEL_DOW:   rd_data = dow_q;
            SEL_YEAR:  rd_data = year_q;
            default:   rd_data = '0;
        endcase
    end

    // R2
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && pend_q && !sec_q[7] && !wr_en) |=> (sec_q[6:0] <= 7'h59));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[7] && !wr_en) |=> $stable(sec_q));

    // R11
    sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_write |=> (sec_q == $past(wr_data) && !pend_q && st_q == ST_IDLE));

    // R5
    hour12_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOUR && !wr_en && hour_q[7]) |=> (hour_q[4:0] != 5'h00));

    // R8
    dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATE && !wr_en && dow_wrap) |=> (dow_q == RW'(8'h01)));

    // R9
    year_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_YEAR && !wr_en && year_wrap) |=> (year_q == '0));

endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_sel = 3'd0;
    logic [7:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_calendar_core i_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [2:0] sel, input logic [7:0] exp);
        @(negedge clk);
        rd_sel = sel;
        #1;
        n_vec++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", tag, sel, rd_data, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_all(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] dw,
                           input logic [7:0] y);
        wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, dt);
        wr(3'd4, mo); wr(3'd5, dw); wr(3'd6, y);
    endtask

    task automatic tick();
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", 3'd0, 8'h00); chk("R1", 3'd1, 8'h00); chk("R1", 3'd2, 8'h00);
        chk("R1", 3'd3, 8'h01); chk("R1", 3'd4, 8'h01); chk("R1", 3'd5, 8'h01);
        chk("R1", 3'd6, 8'h00);
    endtask

    task automatic t_seconds();
        set_all(8'h08, 8'h12, 8'h05, 8'h10, 8'h03, 8'h02, 8'h21);
        tick(); chk("R2", 3'd0, 8'h09);
        tick(); chk("R2", 3'd0, 8'h10);
        wr(3'd0, 8'h59);
        tick(); chk("R2", 3'd0, 8'h00); chk("R2", 3'd1, 8'h13);
    endtask

    task automatic t_minutes();
        set_all(8'h59, 8'h59, 8'h09, 8'h10, 8'h03, 8'h02, 8'h21);
        tick(); chk("R3", 3'd1, 8'h00); chk("R3", 3'd2, 8'h10);
    endtask

    task automatic t_hour24();
        set_all(8'h59, 8'h59, 8'h19, 8'h05, 8'h03, 8'h03, 8'h21);
        tick(); chk("R4", 3'd2, 8'h20); chk("R4", 3'd3, 8'h05);
        set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h03, 8'h03, 8'h21);
        tick(); chk("R4", 3'd2, 8'h00); chk("R4", 3'd3, 8'h06);
        chk("R8", 3'd5, 8'h04);
    endtask

    task automatic t_hour12();
        set_all(8'h59, 8'h59, 8'h91, 8'h05, 8'h03, 8'h03, 8'h21);
        tick(); chk("R5", 3'd2, 8'hB2); chk("R5", 3'd3, 8'h05);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick(); chk("R5", 3'd2, 8'hA1);
        set_all(8'h59, 8'h59, 8'hB1, 8'h05, 8'h03, 8'h03, 8'h21);
        tick(); chk("R5", 3'd2, 8'h92); chk("R5", 3'd3, 8'h06);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick(); chk("R5", 3'd2, 8'h81);
    endtask

    task automatic t_month_len();
        set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h01, 8'h23);
        tick(); chk("R6", 3'd3, 8'h01); chk("R6", 3'd4, 8'h05);
        set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h01, 8'h23);
        tick(); chk("R6", 3'd3, 8'h31); chk("R6", 3'd4, 8'h01);
        set_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h01, 8'h23);
        tick(); chk("R6", 3'd3, 8'h01); chk("R6", 3'd4, 8'h02);
    endtask

    task automatic t_leap();
        set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h01, 8'h24);
        tick(); chk("R7", 3'd3, 8'h29); chk("R7", 3'd4, 8'h02);
        wr(3'd1, 8'h59); wr(3'd2, 8'h23); wr(3'd0, 8'h59);
        tick(); chk("R7", 3'd3, 8'h01); chk("R7", 3'd4, 8'h03);
        set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h01, 8'h23);
        tick(); chk("R7", 3'd3, 8'h01); chk("R7", 3'd4, 8'h03);
        set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h01, 8'h10);
        tick(); chk("R7", 3'd3, 8'h01); chk("R7", 3'd4, 8'h03);
        set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h01, 8'h00);
        tick(); chk("R7", 3'd3, 8'h29);
    endtask

    task automatic t_year();
        set_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h07, 8'h99);
        tick();
        chk("R9", 3'd3, 8'h01); chk("R9", 3'd4, 8'h01); chk("R9", 3'd6, 8'h00);
        chk("R8", 3'd5, 8'h01);
        set_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h02, 8'h41);
        tick(); chk("R9", 3'd6, 8'h42);
    endtask

    task automatic t_halt();
        set_all(8'h90, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        tick(); tick(); tick();
        chk("R10", 3'd0, 8'h90);
        wr(3'd0, 8'h10);
        chk("R10", 3'd0, 8'h10);
        tick(); chk("R10", 3'd0, 8'h11);
    endtask

    task automatic t_priority();
        set_all(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        // tick and seconds write in the same cycle: write wins, tick discarded (R11)
        @(negedge clk);
        tick_1hz = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h30;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        repeat (10) @(negedge clk);
        chk("R11", 3'd0, 8'h30);
        // hour write landing on the minute step defers it without loss (R11)
        set_all(8'h59, 8'h05, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd2; wr_data = 8'h07;
        @(negedge clk) wr_en = 1'b0;
        repeat (10) @(negedge clk);
        chk("R11", 3'd0, 8'h00); chk("R11", 3'd1, 8'h06); chk("R11", 3'd2, 8'h07);
    endtask

    task automatic t_readmap();
        wr(3'd1, 8'hFF); chk("R12", 3'd1, 8'h7F);
        wr(3'd2, 8'h7F); chk("R12", 3'd2, 8'h3F);
        wr(3'd5, 8'hFE); chk("R12", 3'd5, 8'h06);
        wr(3'd7, 8'h55); chk("R12", 3'd7, 8'h00);
        chk("R12", 3'd6, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_seconds();
        t_minutes();
        t_hour24();
        t_hour12();
        t_month_len();
        t_leap();
        t_year();
        t_halt();
        t_priority();
        t_readmap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule